// File: doc/BRIEF.md
# Receive Lane Deserializer with Loopback and Timing Fallback

The block takes one serial bit per bit clock from one of three places: receive lane A, receive lane B, or a loopback copy of the local transmit stream. It packs the chosen stream into 16-bit parallel words and raises a one-cycle byte strobe with every word. The bit clock reaches the block already recovered. No word alignment is attempted, so a word starts wherever the free-running bit counter happens to stand.

While the chosen stream toggles, the strobe is produced by dividing the bit clock by 16. When the line goes quiet, or the external signal-detect input drops, the strobe follows a reference-derived byte pulse instead. Software does not need to request this change. The block moves between the two timing sources only at a word boundary, so a word is never cut short at the switch.

Top module: `rx_deser`

## Requirements
- R1: With `loop_en_i` high, the loopback bit is the source, whatever `lane_b_sel_i` holds.
- R2: With `loop_en_i` low, `lane_b_sel_i` high selects lane B and low selects lane A.
- R3: Within a word, the earliest received bit lands in `word_o[0]` and the later bits fill bits 1 to 15 in arrival order.
- R4: In recovered timing, `byte_stb_o` pulses once every 16 bit clocks and ignores the reference pulse. `word_o` changes only in the cycle the strobe is high.
- R5: No framing is done. The offset between the serial stream and the word boundaries is arbitrary but stays fixed from word to word.
- R6: With no data present, `byte_stb_o` repeats `ref_stb_i` one bit clock later.
- R7: A serial bit reaches `word_o` no more than 32 bit clocks after the clock edge that samples it.
- R8: Data counts as present once the chosen bit toggles. It counts as absent after 64 (`ACT_WIN`) bit clocks with no toggle, or while `sig_det_i` is low.
- R9: The timing source changes only at a word boundary. When the reference pulse is 16 cycles apart and in step with the strobe, the strobe spacing stays at 16 through the switch.
- R10: During reset, `word_o` is 0 and `byte_stb_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_a_i | input | 1 | Serial receive lane A |
| lane_b_i | input | 1 | Serial receive lane B |
| loop_bit_i | input | 1 | Serial bit from the local transmitter |
| loop_en_i | input | 1 | 1 selects the loopback bit |
| lane_b_sel_i | input | 1 | 1 selects lane B, 0 selects lane A (when not looping back) |
| sig_det_i | input | 1 | External data-present indication |
| ref_stb_i | input | 1 | Reference-derived byte pulse |
| word_o | output | 16 | Deserialized word, bit 0 received first |
| byte_stb_o | output | 1 | Byte strobe, high for one cycle with each new word |

## Verification
Each lane and the loopback bit carries a different pseudo-random sequence. Every 16-bit window of each sequence is unique, so the bench can recover the bit offset of each word and attribute the word to exactly one source. This distinguishes a wrong lane, reversed bit order, excess latency and offset drift between words. The select table covers all four combinations of loopback and lane select. A shifted reference pulse then separates recovered timing from reference timing. Two kinds of dead input drive the fallback: a constant-zero line and a dropped signal-detect. The strobe spacing is checked across the change back to recovered timing.

// File: rtl/rx_deser_pkg.sv
package rx_deser_pkg;
  typedef enum logic {TIM_REF = 1'b0, TIM_REC = 1'b1} tim_mode_e;
  typedef enum logic [1:0] {SRC_A = 2'd0, SRC_B = 2'd1, SRC_LOOP = 2'd2} src_e;
endpackage

// File: rtl/rx_src_sel.sv
module rx_src_sel
  import rx_deser_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lane_a_i,
  input  logic lane_b_i,
  input  logic loop_bit_i,
  input  logic loop_en_i,
  input  logic lane_b_sel_i,
  output logic bit_o
);
  src_e src;
  logic bit_d;

  always_comb begin
    if (loop_en_i)         src = SRC_LOOP;
    else if (lane_b_sel_i) src = SRC_B;
    else                   src = SRC_A;
  end

  always_comb begin
    unique case (src)
      SRC_LOOP: bit_d = loop_bit_i;
      SRC_B:    bit_d = lane_b_i;
      default:  bit_d = lane_a_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_o <= 1'b0;
    else         bit_o <= bit_d;
  end

  // R1
  loop_override_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_en_i |=> bit_o == $past(loop_bit_i));
  // R2
  lane_b_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loop_en_i && lane_b_sel_i) |=> bit_o == $past(lane_b_i));
  // R2
  lane_a_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loop_en_i && !lane_b_sel_i) |=> bit_o == $past(lane_a_i));
endmodule

// File: rtl/rx_act_det.sv
module rx_act_det #(
  parameter int WIN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic sig_det_i,
  output logic present_o
);
  localparam int QW = (WIN > 2) ? $clog2(WIN) : 1;
  localparam logic [QW-1:0] QLAST = QW'(WIN - 1);

  logic          prev_q;
  logic          pres_q;
  logic [QW-1:0] quiet_q;
  logic          toggle;

  assign toggle    = bit_i ^ prev_q;
  assign present_o = pres_q & sig_det_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      pres_q  <= 1'b0;
      quiet_q <= '0;
    end else begin
      prev_q <= bit_i;
      if (toggle) begin
        pres_q  <= 1'b1;
        quiet_q <= '0;
      end else if (quiet_q == QLAST) begin
        pres_q  <= 1'b0;
      end else begin
        quiet_q <= quiet_q + 1'b1;
      end
    end
  end

  // R8
  absent_after_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pres_q) |-> $past(quiet_q) == QLAST);
  // R8
  present_on_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pres_q) |-> $past(bit_i) != $past(prev_q));
endmodule

// File: rtl/rx_byte_timer.sv
module rx_byte_timer
  import rx_deser_pkg::*;
#(
  parameter int W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic present_i,
  input  logic ref_stb_i,
  output logic bnd_o,
  output logic stb_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] CLAST = CW'(W - 1);

  tim_mode_e     mode_q;
  logic [CW-1:0] cnt_q;

  always_comb bnd_o = (mode_q == TIM_REC) ? (cnt_q == CLAST) : ref_stb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= TIM_REF;
      cnt_q  <= '0;
      stb_o  <= 1'b0;
    end else begin
      stb_o <= bnd_o;
      cnt_q <= bnd_o ? '0 : cnt_q + 1'b1;
      if (bnd_o) mode_q <= present_i ? TIM_REC : TIM_REF;
    end
  end

  // R9
  mode_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> stb_o);
  // R4
  strobe_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> cnt_q == '0);
  // R6
  ref_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == TIM_REF && $past(mode_q == TIM_REF) && $past(rst_ni))
      |-> stb_o == $past(ref_stb_i));
endmodule

// File: rtl/rx_word_asm.sv
module rx_word_asm #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  input  logic         bnd_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sh_q;
  logic [W-1:0] sh_d;

  // newest bit enters at the top, so the oldest ends at bit 0
  assign sh_d = {bit_i, sh_q[W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      word_o <= '0;
    end else begin
      sh_q <= sh_d;
      if (bnd_i) word_o <= sh_d;
    end
  end

  // R3
  newest_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_i |=> word_o[W-1] == $past(bit_i));
  // R4
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd_i |=> $stable(word_o));
endmodule

// File: rtl/rx_deser.sv
module rx_deser #(
  parameter int W       = 16,
  parameter int ACT_WIN = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         lane_a_i,
  input  logic         lane_b_i,
  input  logic         loop_bit_i,
  input  logic         loop_en_i,
  input  logic         lane_b_sel_i,
  input  logic         sig_det_i,
  input  logic         ref_stb_i,
  output logic [W-1:0] word_o,
  output logic         byte_stb_o
);
  logic sel_bit;
  logic present;
  logic bnd;

  rx_src_sel u_src (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lane_a_i     (lane_a_i),
    .lane_b_i     (lane_b_i),
    .loop_bit_i   (loop_bit_i),
    .loop_en_i    (loop_en_i),
    .lane_b_sel_i (lane_b_sel_i),
    .bit_o        (sel_bit)
  );

  rx_act_det #(.WIN(ACT_WIN)) u_act (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_i     (sel_bit),
    .sig_det_i (sig_det_i),
    .present_o (present)
  );

  rx_byte_timer #(.W(W)) u_tim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .present_i (present),
    .ref_stb_i (ref_stb_i),
    .bnd_o     (bnd),
    .stb_o     (byte_stb_o)
  );

  rx_word_asm #(.W(W)) u_asm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (sel_bit),
    .bnd_i  (bnd),
    .word_o (word_o)
  );
endmodule

// File: tb/tb_rx_deser.sv
module tb_rx_deser;
  localparam int W   = 16;
  localparam int WIN = 64;
  localparam int HN  = 4096;
  localparam logic [15:0] TAPS = 16'hB400;
  // {loop_en, lane_b_sel, expected source}
  localparam logic [3:0] CASES [5] = '{
    {1'b0, 1'b0, 2'd0}, {1'b0, 1'b1, 2'd1}, {1'b1, 1'b0, 2'd2},
    {1'b1, 1'b1, 2'd2}, {1'b0, 1'b0, 2'd0}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic lane_a = 1'b0, lane_b = 1'b0, loop_bit = 1'b0;
  logic loop_en = 1'b0, sel_b = 1'b0, sig_det = 1'b1, ref_stb = 1'b0;
  logic [W-1:0] word;
  logic stb;

  rx_deser #(.W(W), .ACT_WIN(WIN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lane_a_i(lane_a), .lane_b_i(lane_b),
    .loop_bit_i(loop_bit), .loop_en_i(loop_en), .lane_b_sel_i(sel_b),
    .sig_det_i(sig_det), .ref_stb_i(ref_stb), .word_o(word), .byte_stb_o(stb));

  int n_chk = 0, n_fail = 0;
  int pos = 0, ref_ph = 0, exp_src = 0, lock_l = -1, last_stb = -1;
  bit quiet = 1'b0, mux_en = 1'b0, gap_en = 1'b0, ref_chk = 1'b0, done = 1'b0;
  logic [15:0] lf_a = 16'hACE1, lf_b = 16'h3B5D, lf_l = 16'h7001;
  bit hist [3][HN];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lstep(input logic [15:0] v);
    return {1'b0, v[15:1]} ^ (v[0] ? TAPS : 16'h0);
  endfunction

  // offset L where word bit i equals the bit driven at pos-L-(W-1-i)
  function automatic int find_lat(input logic [W-1:0] w, input int src);
    for (int l = 0; l <= 16; l++) begin
      bit ok = 1'b1;
      for (int i = 0; i < W; i++)
        if (w[i] != hist[src][(pos - l - (W - 1 - i)) % HN]) ok = 1'b0;
      if (ok) return l;
    end
    return -1;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (stb) begin
        if (gap_en && last_stb >= 0) chk(pos - last_stb == W, "R4/R9 spacing", pos - last_stb, W);
        last_stb = pos;
        if (mux_en) begin
          int l;
          l = find_lat(word, exp_src);
          chk(l >= 0, (exp_src == 2) ? "R1/R3 source+order" : "R2/R3 source+order", int'(word), -1);
          if (l >= 0) begin
            chk(l + W - 1 <= 32, "R7 latency", l + W - 1, 32);
            if (lock_l < 0) lock_l = l;
            else chk(l == lock_l, "R5 offset stable", l, lock_l);
          end
        end
      end
      if (ref_chk) chk(stb == ref_stb, "R6 ref follow", int'(stb), int'(ref_stb));
    end
    pos++;
    lf_a = lstep(lf_a); lf_b = lstep(lf_b); lf_l = lstep(lf_l);
    lane_a   = quiet ? 1'b0 : lf_a[0];
    lane_b   = quiet ? 1'b0 : lf_b[0];
    loop_bit = quiet ? 1'b0 : lf_l[0];
    hist[0][pos % HN] = lane_a;
    hist[1][pos % HN] = lane_b;
    hist[2][pos % HN] = loop_bit;
    ref_stb = ((pos + ref_ph) % W) == 0;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    int ph0, ph1;
    wait_n(5);
    // R10 reset state
    chk(word == '0, "R10 reset word", int'(word), 0);
    chk(stb == 1'b0, "R10 reset strobe", int'(stb), 0);
    rst_n = 1'b1;
    wait_n(80);
    last_stb = -1; gap_en = 1'b1;

    foreach (CASES[k]) begin
      loop_en = CASES[k][3];
      sel_b   = CASES[k][2];
      exp_src = int'(CASES[k][1:0]);
      lock_l  = -1;
      wait_n(48);
      mux_en = 1'b1;
      wait_n(W * 5);
      mux_en = 1'b0;
      chk(lock_l >= 0, "R5 offset found", lock_l, 0);
    end

    // R4: shifted reference pulse has no effect in recovered timing
    ph0 = last_stb % W;
    ref_ph = 5;
    wait_n(64);
    chk(last_stb % W == ph0, "R4 ref ignored", last_stb % W, ph0);

    // R8: quiet line, still recovered before the window expires
    gap_en = 1'b0;
    quiet = 1'b1;
    wait_n(WIN / 2);
    chk(last_stb % W == ph0, "R8 before window", last_stb % W, ph0);
    wait_n(WIN + 40);
    ref_chk = 1'b1;
    wait_n(48);
    ref_chk = 1'b0;
    ph1 = last_stb % W;
    chk(ph1 != ph0, "R8 fallback phase", ph1, ph0);

    // R9: back to recovered timing without a short word
    last_stb = -1; gap_en = 1'b1;
    quiet = 1'b0;
    wait_n(80);
    chk(last_stb % W == ph1, "R9 phase kept", last_stb % W, ph1);

    // R8: signal-detect low forces reference timing
    gap_en = 1'b0;
    ref_ph = 9;
    sig_det = 1'b0;
    wait_n(48);
    ref_chk = 1'b1;
    wait_n(48);
    ref_chk = 1'b0;
    sig_det = 1'b1;
    last_stb = -1; gap_en = 1'b1;
    wait_n(80);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule